// File: doc/BRIEF.md
# SMBus Target Front End with Bus Timeout

This block is the bit-level client side of an SMBus link. It samples the clock and data lines with the system clock through a two-stage synchronizer and detects START, repeated START and STOP conditions. It shifts in an address byte and answers two addresses. The first is its own 7-bit address, taken from an input. The second is the Alert Response Address 7'b0001100, which it answers only while the local alert input is high. Once addressed, it either receives data bytes and acknowledges each one, or transmits bytes supplied by the host logic until the bus host signals the end of the read with a NACK.

The data line output is a pull-low enable. It is high when the block pulls SDA low and low when it releases the line, so the block never drives the line high. Two counters guard the protocol state. One ends a transaction when SCL has been low for too long, and software can turn it off with a disable input. The other ends a transaction when both lines have been high for too long. Both thresholds are parameters given in system-clock cycles.

The controller has eight states. IDLE waits for a START. ADDR shifts in the address byte. ACK pulls SDA low for one clock slot. RX shifts in a write byte. TX shifts out a read byte. TX_ACK releases the line and samples the host's acknowledge. TX_NEXT loads the next read byte. WAIT ignores the bus. The transitions are as follows. Any state goes to IDLE on STOP, SCL-low timeout or bus idle, and to ADDR on START. ADDR goes to ACK on an address match, or to WAIT otherwise, after the eighth bit. ACK goes to RX (write) or TX (read) at the SCL fall that ends the acknowledge slot. RX goes to ACK after its eighth bit. TX goes to TX_ACK after its eighth bit. TX_ACK goes to TX_NEXT when the host acknowledges, or to WAIT when it does not. TX_NEXT goes to TX on the next SCL fall.

Top module: `smbt_target`

## Requirements
- R1: Bytes are 8 bits, most significant bit first, each bit sampled on a rising SCL edge. For a write data byte, `rx_valid_o` pulses for exactly one cycle, with `rx_byte_o` holding the byte, after the eighth bit.
- R2: For every write data byte of a selected transaction, `sda_pull_o` is high from the SCL fall after the eighth bit to the SCL fall after the ninth bit.
- R3: An address byte whose bits 7:1 equal `own_addr_i` is acknowledged and sets `addr_match_o`. Any other address (apart from R4) is not acknowledged, and the rest of that transaction is ignored: no ACK and no `rx_valid_o`.
- R4: The address 7'b0001100 is acknowledged only while `alert_i` is high.
- R5: When bit 0 of the address byte is 1, `tx_byte_i` is captured at the SCL fall that ends the preceding acknowledge slot and is shifted out MSB first. A host ACK (SDA low in the ninth slot) starts the next byte. A host NACK makes the block release SDA and ignore the bus until STOP or START.
- R6: A STOP (SDA rising while SCL is high) returns the block to idle and clears `addr_match_o`. Clocked bytes that follow without a START are ignored.
- R7: With `timeout_dis_i` low, SCL held low for LOW_TO_CYCLES cycles resets the protocol state: SDA is released and `addr_match_o` clears. With `timeout_dis_i` high, no such reset occurs.
- R8: A repeated START in the middle of a transaction restarts address reception.
- R9: SCL and SDA both high for IDLE_CYCLES cycles resets the protocol state, and the bytes that follow are ignored until a START.
- R10: `sda_pull_o` changes only while the synchronized SCL is low, so SDA stays stable during every SCL high phase.
- R11: After reset `sda_pull_o`, `rx_valid_o` and `addr_match_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_pull_o | output | 1 | High pulls SDA low; low releases it |
| own_addr_i | input | 7 | Target's own 7-bit address |
| alert_i | input | 1 | Alert pending; enables the Alert Response Address |
| timeout_dis_i | input | 1 | High disables the SCL-low timeout |
| tx_byte_i | input | 8 | Next byte to send in a read |
| rx_valid_o | output | 1 | One-cycle strobe for a received data byte |
| rx_byte_o | output | 8 | Last received data byte |
| addr_match_o | output | 1 | Target selected in the current transaction |

## Verification
The hardest situations to reach are the two protocol resets, because a well-behaved host never parks the bus in the middle of a byte. The bench splits its byte task into a bits phase and a separate acknowledge phase. This lets it stop the clock low right after an address byte, while the block is holding its ACK, and watch whether the pull is dropped, once with the timeout enabled and once with it disabled. For the idle case it raises both lines in the middle of a write and holds them past the threshold. It then clocks a full byte to show that the block no longer acknowledges.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT,
        ST_WAIT
    } smbt_state_e;

    localparam int unsigned ADDR_W = 7;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BIT_CNT_W = $clog2(BYTE_W);

    localparam logic [ADDR_W-1:0] ALERT_RESP_ADDR = 7'b0001100;

endpackage

// File: rtl/smbt_sync.sv
module smbt_sync #(
    parameter int unsigned LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_i,
    output logic [LINES-1:0] line_s,
    output logic [LINES-1:0] line_prev
);

    // Idle bus level is high, so every stage resets to 1.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                prev_q <= 1'b1;
            end else begin
                meta_q <= line_i[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign line_s[g]    = sync_q;
        assign line_prev[g] = prev_q;
    end

endmodule

// File: rtl/smbt_span.sv
module smbt_span #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] SAT  = CW'(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Counts consecutive cycles with run high; saturates so hit fires once.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = run && (cnt_q == LAST);

endmodule

// File: rtl/smbt_fsm.sv
module smbt_fsm
    import smbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              abort,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              alert,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_pull,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              addr_match
);

    smbt_state_e           state_q, state_d;
    logic [BIT_CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0]     sr_q;
    logic [BYTE_W-1:0]     tx_q;
    logic                  ack_on_q;
    logic                  rnw_q;
    logic                  match_q;
    logic                  rxv_q;
    logic [BYTE_W-1:0]     rxb_q;

    logic [BYTE_W-1:0]     in_byte;
    logic                  last_bit;
    logic                  addr_hit;

    assign in_byte  = {sr_q[BYTE_W-2:0], sda_s};
    assign last_bit = (bitcnt_q == BIT_CNT_W'(BYTE_W - 1));
    assign addr_hit = (in_byte[BYTE_W-1:1] == own_addr) ||
                      ((in_byte[BYTE_W-1:1] == ALERT_RESP_ADDR) && alert);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_ADDR:    if (scl_rise && last_bit) state_d = addr_hit ? ST_ACK : ST_WAIT;
                ST_ACK:     if (scl_fall && ack_on_q) state_d = rnw_q ? ST_TX : ST_RX;
                ST_RX:      if (scl_rise && last_bit) state_d = ST_ACK;
                ST_TX:      if (scl_rise && last_bit) state_d = ST_TX_ACK;
                ST_TX_ACK:  if (scl_rise && ack_on_q) state_d = sda_s ? ST_WAIT : ST_TX_NEXT;
                ST_TX_NEXT: if (scl_fall) state_d = ST_TX;
                ST_WAIT:    state_d = ST_WAIT;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift registers, bit counter and slot flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            sr_q     <= '0;
            tx_q     <= '0;
            ack_on_q <= 1'b0;
            rnw_q    <= 1'b0;
            match_q  <= 1'b0;
            rxv_q    <= 1'b0;
            rxb_q    <= '0;
        end else begin
            rxv_q <= 1'b0;
            if (abort) begin
                match_q  <= 1'b0;
                ack_on_q <= 1'b0;
                bitcnt_q <= '0;
            end else if (start_det) begin
                match_q  <= 1'b0;
                ack_on_q <= 1'b0;
                rnw_q    <= 1'b0;
                bitcnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sr_q     <= in_byte;
                            bitcnt_q <= bitcnt_q + 1'b1;
                            if (last_bit) begin
                                rnw_q    <= sda_s;
                                match_q  <= addr_hit;
                                ack_on_q <= 1'b0;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!ack_on_q) begin
                                ack_on_q <= 1'b1;
                            end else begin
                                ack_on_q <= 1'b0;
                                bitcnt_q <= '0;
                                if (rnw_q) tx_q <= tx_byte;
                            end
                        end
                    end
                    ST_RX: begin
                        if (scl_rise) begin
                            sr_q     <= in_byte;
                            bitcnt_q <= bitcnt_q + 1'b1;
                            if (last_bit) begin
                                rxv_q    <= 1'b1;
                                rxb_q    <= in_byte;
                                ack_on_q <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt_q <= bitcnt_q + 1'b1;
                            if (last_bit) ack_on_q <= 1'b0;
                        end
                        if (scl_fall) tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                    end
                    ST_TX_ACK: begin
                        if (scl_fall && !ack_on_q) ack_on_q <= 1'b1;
                    end
                    ST_TX_NEXT: begin
                        if (scl_fall) begin
                            tx_q     <= tx_byte;
                            bitcnt_q <= '0;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        sda_pull = 1'b0;
        unique case (state_q)
            ST_ACK:    sda_pull = ack_on_q;
            ST_TX:     sda_pull = ~tx_q[BYTE_W-1];
            ST_TX_ACK: sda_pull = ~ack_on_q & ~tx_q[BYTE_W-1];
            default:   sda_pull = 1'b0;
        endcase
    end

    assign rx_valid   = rxv_q;
    assign rx_byte    = rxb_q;
    assign addr_match = match_q;

endmodule

// File: rtl/smbt_target.sv
module smbt_target
    import smbt_pkg::*;
#(
    parameter int unsigned LOW_TO_CYCLES = 1_500_000,
    parameter int unsigned IDLE_CYCLES   = 7_500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              alert_i,
    input  logic              timeout_dis_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              addr_match_o
);

    localparam int unsigned SCL_IDX = 0;
    localparam int unsigned SDA_IDX = 1;

    logic [1:0] line_s;
    logic [1:0] line_prev;
    logic       scl_s, sda_s, scl_p, sda_p;
    logic       scl_rise, scl_fall, start_det, stop_det;
    logic       to_evt, idle_evt, abort;

    smbt_sync #(.LINES(2)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   ({sda_i, scl_i}),
        .line_s   (line_s),
        .line_prev(line_prev)
    );

    assign scl_s = line_s[SCL_IDX];
    assign sda_s = line_s[SDA_IDX];
    assign scl_p = line_prev[SCL_IDX];
    assign sda_p = line_prev[SDA_IDX];

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    smbt_span #(.LIMIT(LOW_TO_CYCLES)) low_span_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (~scl_s & ~timeout_dis_i),
        .hit  (to_evt)
    );

    smbt_span #(.LIMIT(IDLE_CYCLES)) idle_span_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (scl_s & sda_s),
        .hit  (idle_evt)
    );

    assign abort = stop_det | to_evt | idle_evt;

    smbt_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .abort     (abort),
        .own_addr  (own_addr_i),
        .alert     (alert_i),
        .tx_byte   (tx_byte_i),
        .sda_pull  (sda_pull_o),
        .rx_valid  (rx_valid_o),
        .rx_byte   (rx_byte_o),
        .addr_match(addr_match_o)
    );

endmodule

// File: rtl/smbt_checker.sv
module smbt_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic stop_det,
    input logic to_evt,
    input logic idle_evt,
    input logic sda_pull_o,
    input logic rx_valid_o,
    input logic addr_match_o
);

    // R1: the received-byte strobe lasts a single cycle
    assert_rx_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R6: a STOP deselects the target
    assert_stop_deselects_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !addr_match_o);

    // R7: an SCL-low timeout releases the line and deselects
    assert_timeout_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        to_evt |=> (!sda_pull_o && !addr_match_o));

    // R9: bus idle releases the line and deselects
    assert_idle_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_evt |=> (!sda_pull_o && !addr_match_o));

    // R10: the pull enable only moves while SCL is low
    assert_pull_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !scl_s);

endmodule

bind smbt_target smbt_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .stop_det    (stop_det),
    .to_evt      (to_evt),
    .idle_evt    (idle_evt),
    .sda_pull_o  (sda_pull_o),
    .rx_valid_o  (rx_valid_o),
    .addr_match_o(addr_match_o)
);

// File: tb/smbt_target_tb_top.sv
module smbt_target_tb_top;

    localparam int unsigned LOW_TO = 200;
    localparam int unsigned IDLE   = 150;
    localparam int H = 8;   // half bit period in clocks
    localparam int Q = 3;   // settle after SCL fall

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic       alert = 1'b0;
    logic       tdis = 1'b1;
    logic [6:0] own = 7'h2E;
    logic [7:0] txb = 8'h96;
    logic       sda_pull, rxv, match;
    logic [7:0] rxb;
    logic       sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    assign sda_bus = sda_h & ~sda_pull;

    smbt_target #(.LOW_TO_CYCLES(LOW_TO), .IDLE_CYCLES(IDLE)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_h),
        .sda_i        (sda_bus),
        .sda_pull_o   (sda_pull),
        .own_addr_i   (own),
        .alert_i      (alert),
        .timeout_dis_i(tdis),
        .tx_byte_i    (txb),
        .rx_valid_o   (rxv),
        .rx_byte_o    (rxb),
        .addr_match_o (match)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compares every strobed byte with the queue head
    always @(negedge clk) begin
        if (rst_n && rxv) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected received byte", rxb, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rxb == e, "R1 received byte", rxb, e);
            end
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_h = 1'b1; wclk(Q);
        scl_h = 1'b1; wclk(H);
        sda_h = 1'b0; wclk(H);
        scl_h = 1'b0; wclk(Q);
    endtask

    task automatic bstop();
        sda_h = 1'b0; wclk(H);
        scl_h = 1'b1; wclk(H);
        sda_h = 1'b1; wclk(H);
    endtask

    task automatic bits8(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; wclk(H);
            scl_h = 1'b1; wclk(H);
            scl_h = 1'b0; wclk(Q);
        end
    endtask

    task automatic ack_slot(output bit acked);
        sda_h = 1'b1; wclk(H);
        scl_h = 1'b1; wclk(Q);
        acked = !sda_bus;
        wclk(H - Q);
        scl_h = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bits8(b);
        ack_slot(acked);
    endtask

    task automatic read_byte(output logic [7:0] b, input bit host_ack, input logic [7:0] next_tx);
        sda_h = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            logic early;
            wclk(H);
            scl_h = 1'b1; wclk(Q);
            early = sda_bus;
            b = {b[6:0], sda_bus};
            wclk(H - Q - 1);
            check(sda_bus == early, "R10 SDA stable while SCL high", sda_bus, early);
            wclk(1);
            scl_h = 1'b0; wclk(Q);
        end
        txb = next_tx;
        sda_h = !host_ack; wclk(H);
        scl_h = 1'b1; wclk(H);
        scl_h = 1'b0; wclk(Q);
        sda_h = 1'b1;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] b;
        logic [7:0] data [4] = '{8'hA5, 8'h3C, 8'h00, 8'hFF};

        wclk(5);
        check(sda_pull == 1'b0, "R11 reset pull", sda_pull, 0);
        check(rxv == 1'b0, "R11 reset strobe", rxv, 0);
        check(match == 1'b0, "R11 reset match", match, 0);
        rst_n = 1'b1;
        wclk(5);

        // Write to own address, several data patterns
        bstart();
        send_byte({own, 1'b0}, a);
        check(a, "R3 own address ACK", a, 1);
        check(match, "R3 match flag set", match, 1);
        foreach (data[i]) begin
            exp_q.push_back(data[i]);
            send_byte(data[i], a);
            check(a, "R2 data byte ACK", a, 1);
        end
        bstop();
        wclk(2);
        check(!match, "R6 STOP clears match", match, 0);

        // Clocking without START after STOP is ignored
        send_byte(8'h55, a);
        check(!a, "R6 byte after STOP ignored", a, 0);
        bstop();

        // Foreign address
        bstart();
        send_byte({7'h11, 1'b0}, a);
        check(!a, "R3 foreign address NACK", a, 0);
        check(!match, "R3 foreign address no match", match, 0);
        send_byte(8'h12, a);
        check(!a, "R3 rest of foreign transaction ignored", a, 0);
        bstop();

        // Alert Response Address gated by alert
        bstart();
        send_byte({7'h0C, 1'b1}, a);
        check(!a, "R4 ARA NACK while alert low", a, 0);
        bstop();
        alert = 1'b1;
        txb = 8'hC3;
        bstart();
        send_byte({7'h0C, 1'b1}, a);
        check(a, "R4 ARA ACK while alert high", a, 1);
        read_byte(b, 1'b0, 8'h00);
        check(b == 8'hC3, "R4 ARA read byte", b, 8'hC3);
        bstop();
        alert = 1'b0;

        // Read from own address: ACK then NACK
        txb = 8'h96;
        bstart();
        send_byte({own, 1'b1}, a);
        check(a, "R5 read address ACK", a, 1);
        read_byte(b, 1'b1, 8'h5A);
        check(b == 8'h96, "R5 first read byte", b, 8'h96);
        read_byte(b, 1'b0, 8'h00);
        check(b == 8'h5A, "R5 second read byte after host ACK", b, 8'h5A);
        read_byte(b, 1'b0, 8'h00);
        check(b == 8'hFF, "R5 line released after NACK", b, 8'hFF);
        check(sda_pull == 1'b0, "R5 no pull after NACK", sda_pull, 0);
        bstop();

        // Repeated START restarts addressing
        bstart();
        send_byte({own, 1'b0}, a);
        exp_q.push_back(8'hA1);
        send_byte(8'hA1, a);
        bstart();
        send_byte({own, 1'b0}, a);
        check(a, "R8 address ACK after repeated START", a, 1);
        exp_q.push_back(8'h7E);
        send_byte(8'h7E, a);
        check(a, "R8 data ACK after repeated START", a, 1);
        bstop();

        // Timeout disabled: pull held through a long SCL low
        tdis = 1'b1;
        bstart();
        bits8({own, 1'b0});
        wclk(6);
        check(sda_pull == 1'b1, "R2 ACK pull during slot", sda_pull, 1);
        wclk(LOW_TO + 50);
        check(sda_pull == 1'b1, "R7 disabled timeout keeps pull", sda_pull, 1);
        ack_slot(a);
        bstop();

        // Timeout enabled: pull dropped after the limit
        tdis = 1'b0;
        bstart();
        bits8({own, 1'b0});
        wclk(6);
        check(sda_pull == 1'b1, "R7 ACK pull before timeout", sda_pull, 1);
        wclk(LOW_TO + 50);
        check(sda_pull == 1'b0, "R7 timeout releases pull", sda_pull, 0);
        check(!match, "R7 timeout clears match", match, 0);
        ack_slot(a);
        check(!a, "R7 no ACK after timeout", a, 0);
        bstop();
        tdis = 1'b1;

        // Bus idle mid-transaction
        bstart();
        send_byte({own, 1'b0}, a);
        check(a, "R9 address ACK before idle", a, 1);
        sda_h = 1'b1; wclk(Q);
        scl_h = 1'b1; wclk(IDLE + 50);
        check(!match, "R9 idle clears match", match, 0);
        scl_h = 1'b0; wclk(Q);
        send_byte(8'h77, a);
        check(!a, "R9 byte after idle ignored", a, 0);
        bstop();

        wclk(10);
        check(exp_q.size() == 0, "R1 all expected bytes received", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule